// File: doc/BRIEF.md
# Pause Flow-Control Resolver

This block settles which directions of link-level pause flow control a full-duplex Ethernet port uses once autonegotiation has finished. It takes the pause-capability bits that the local port and the link partner advertised, each a symmetric-pause bit and an asymmetric-direction bit, together with the mode software requested and the negotiated duplex. From these it produces a registered two-bit mode and separate transmit-pause and receive-pause enables.

The result changes only on a single-cycle resolve strobe, and only when autonegotiation is both enabled and reported complete. The block also gates the receive-buffer watermark thresholds. The low and high watermarks, and the XON-send flag that travels with the low watermark, reach the MAC only while the resolved mode lets the port transmit pause frames. An out-of-range request raises a sticky-until-next-strobe configuration error and leaves the mode as it was.

Top module: `pause_resolver`

## Requirements
- R1: After reset the mode is 0 (none), both enables are 0, the error flag is 0, and both watermark outputs are all zero.
- R2: The mode and enables load only in the cycle after a resolveStb pulse that sees anEnable=1 and anDone=1 with a legal request. In every other cycle they keep their value.
- R3: The request encoding is 0 = none, 1 = receive-only, 2 = transmit-only, 3 = full, and 4 = default, which is treated as full. On any strobe, a request of 5, 6 or 7 sets cfgErr and leaves the mode unchanged. A strobe with a legal request clears cfgErr.
- R4: When both the local and partner symmetric bits are 1, the result is full if full or default was requested, and receive-only otherwise. The asymmetric bits have no effect in this case.
- R5: Local symmetric 0 and asymmetric 1, with partner symmetric 1 and asymmetric 1, resolves to transmit-only (mode 2).
- R6: Local symmetric 1 and asymmetric 1, with partner symmetric 0 and asymmetric 1, resolves to receive-only (mode 1).
- R7: Every advertisement combination not covered by R4 to R6 resolves to none (mode 0).
- R8: When fullDuplex is 0 at the resolve strobe, the mode becomes none, whatever the advertisement bits are.
- R9: modeOut uses 0 none, 1 receive-only, 2 transmit-only, 3 full. rxPauseEn is 1 for modes 1 and 3, and txPauseEn is 1 for modes 2 and 3.
- R10: While txPauseEn is 1, highWaterOut equals highWaterIn and lowWaterOut[WM_W-1:0] equals lowWaterIn. Otherwise both outputs are all zero.
- R11: lowWaterOut[WM_W] is the XON-send flag. It equals xonEnable while txPauseEn is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resolveStb | input | 1 | One-cycle request to resolve |
| anEnable | input | 1 | Autonegotiation enabled |
| anDone | input | 1 | Autonegotiation reported complete |
| reqMode | input | 3 | Requested mode (0..3, 4 = default, 5..7 illegal) |
| localPause | input | 1 | Local symmetric pause advertised |
| localAsym | input | 1 | Local asymmetric direction advertised |
| peerPause | input | 1 | Partner symmetric pause advertised |
| peerAsym | input | 1 | Partner asymmetric direction advertised |
| fullDuplex | input | 1 | Negotiated duplex is full |
| xonEnable | input | 1 | Software enables XON sending |
| lowWaterIn | input | WM_W | Programmed low watermark |
| highWaterIn | input | WM_W | Programmed high watermark |
| modeOut | output | 2 | Resolved mode |
| txPauseEn | output | 1 | Transmit pause enable |
| rxPauseEn | output | 1 | Receive pause enable |
| cfgErr | output | 1 | Illegal request seen on the last strobe |
| lowWaterOut | output | WM_W+1 | Gated low watermark with the XON flag in the top bit |
| highWaterOut | output | WM_W | Gated high watermark |

## Verification
The assertions check the following on every cycle:
- the mode holds steady without a qualifying strobe, and autonegotiation gating keeps it unchanged;
- a half-duplex strobe yields none;
- symmetric pause is downgraded when less than full was requested;
- an illegal request raises the error flag;
- the enable bits agree with the mode;
- the watermarks read zero whenever transmit pause is off.

Only the bench's exhaustive sweep over every request, advertisement pattern and duplex value shows the complete resolution table, including the asymmetric cases and the none fallthrough. The same sweep shows the exact values passed through on the watermark and XON bits.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_FULL = 2'd3
  } fcMode_e;

  localparam logic [2:0] REQ_DEFAULT = 3'd4;

  typedef struct packed {
    logic    loadMode;
    logic    setErr;
    logic    clrErr;
    fcMode_e wantMode;
  } ctrlStb_t;
endpackage

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
(
  input  logic       resolveStb,
  input  logic       anEnable,
  input  logic       anDone,
  input  logic [2:0] reqMode,
  output ctrlStb_t   stb
);
  logic legalReq;
  logic anReady;

  always_comb begin
    legalReq = (reqMode <= REQ_DEFAULT);
    anReady  = anEnable && anDone;
    stb.wantMode = (reqMode == REQ_DEFAULT) ? FC_FULL : fcMode_e'(reqMode[1:0]);
    stb.loadMode = resolveStb && legalReq && anReady;
    stb.setErr   = resolveStb && !legalReq;
    stb.clrErr   = resolveStb && legalReq;
  end
endmodule

// File: rtl/pfc_dpath.sv
module pfc_dpath
  import pfc_pkg::*;
#(
  parameter int WM_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStb_t        stb,
  input  logic            localPause,
  input  logic            localAsym,
  input  logic            peerPause,
  input  logic            peerAsym,
  input  logic            fullDuplex,
  input  logic            xonEnable,
  input  logic [WM_W-1:0] lowWaterIn,
  input  logic [WM_W-1:0] highWaterIn,
  output fcMode_e         modeQ,
  output logic            txEnQ,
  output logic            rxEnQ,
  output logic            errQ,
  output logic [WM_W:0]   lowWaterOut,
  output logic [WM_W-1:0] highWaterOut
);
  localparam int XON_POS = WM_W;

  fcMode_e tableMode;
  fcMode_e nextMode;

  always_comb begin
    if (localPause && peerPause)
      tableMode = (stb.wantMode == FC_FULL) ? FC_FULL : FC_RX;
    else if (!localPause && localAsym && peerPause && peerAsym)
      tableMode = FC_TX;
    else if (localPause && localAsym && !peerPause && peerAsym)
      tableMode = FC_RX;
    else
      tableMode = FC_NONE;
    nextMode = fullDuplex ? tableMode : FC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= FC_NONE;
      txEnQ <= 1'b0;
      rxEnQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      if (stb.loadMode) begin
        modeQ <= nextMode;
        txEnQ <= (nextMode == FC_TX) || (nextMode == FC_FULL);
        rxEnQ <= (nextMode == FC_RX) || (nextMode == FC_FULL);
      end
      if (stb.setErr)      errQ <= 1'b1;
      else if (stb.clrErr) errQ <= 1'b0;
    end
  end

  for (genvar b = 0; b < WM_W; b++) begin : g_wmGate
    assign lowWaterOut[b]  = lowWaterIn[b] & txEnQ;
    assign highWaterOut[b] = highWaterIn[b] & txEnQ;
  end
  assign lowWaterOut[XON_POS] = xonEnable & txEnQ;

  // R8
  half_duplex_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadMode && !fullDuplex) |=> (modeQ == FC_NONE));

  // R2
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadMode |=> $stable(modeQ));

  // R4
  sym_downgrade_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadMode && fullDuplex && localPause && peerPause && stb.wantMode != FC_FULL)
      |=> (modeQ == FC_RX));

  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setErr |=> errQ);

  // R9
  enable_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEnQ == modeQ[1]) && (rxEnQ == modeQ[0]));

  // R10
  wm_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnQ |-> (lowWaterOut == '0 && highWaterOut == '0));
endmodule

// File: rtl/pause_resolver.sv
module pause_resolver
  import pfc_pkg::*;
#(
  parameter int WM_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            resolveStb,
  input  logic            anEnable,
  input  logic            anDone,
  input  logic [2:0]      reqMode,
  input  logic            localPause,
  input  logic            localAsym,
  input  logic            peerPause,
  input  logic            peerAsym,
  input  logic            fullDuplex,
  input  logic            xonEnable,
  input  logic [WM_W-1:0] lowWaterIn,
  input  logic [WM_W-1:0] highWaterIn,
  output logic [1:0]      modeOut,
  output logic            txPauseEn,
  output logic            rxPauseEn,
  output logic            cfgErr,
  output logic [WM_W:0]   lowWaterOut,
  output logic [WM_W-1:0] highWaterOut
);
  ctrlStb_t stb;
  fcMode_e  modeQ;

  pfc_ctrl u_ctrl (
    .resolveStb (resolveStb),
    .anEnable   (anEnable),
    .anDone     (anDone),
    .reqMode    (reqMode),
    .stb        (stb)
  );

  pfc_dpath #(.WM_W(WM_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .localPause   (localPause),
    .localAsym    (localAsym),
    .peerPause    (peerPause),
    .peerAsym     (peerAsym),
    .fullDuplex   (fullDuplex),
    .xonEnable    (xonEnable),
    .lowWaterIn   (lowWaterIn),
    .highWaterIn  (highWaterIn),
    .modeQ        (modeQ),
    .txEnQ        (txPauseEn),
    .rxEnQ        (rxPauseEn),
    .errQ         (cfgErr),
    .lowWaterOut  (lowWaterOut),
    .highWaterOut (highWaterOut)
  );

  assign modeOut = modeQ;

  // R2
  an_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resolveStb && !(anEnable && anDone)) |=> $stable(modeOut));
endmodule

// File: tb/sim_pause_resolver.sv
module sim_pause_resolver;
  localparam int WM_W = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            resolveStb = 1'b0;
  logic            anEnable = 1'b0;
  logic            anDone = 1'b0;
  logic [2:0]      reqMode = '0;
  logic            localPause = 1'b0;
  logic            localAsym = 1'b0;
  logic            peerPause = 1'b0;
  logic            peerAsym = 1'b0;
  logic            fullDuplex = 1'b0;
  logic            xonEnable = 1'b0;
  logic [WM_W-1:0] lowWaterIn = 16'h1234;
  logic [WM_W-1:0] highWaterIn = 16'hABCD;
  logic [1:0]      modeOut;
  logic            txPauseEn;
  logic            rxPauseEn;
  logic            cfgErr;
  logic [WM_W:0]   lowWaterOut;
  logic [WM_W-1:0] highWaterOut;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;
  int expMode = 0;
  int expErr = 0;

  always #5 clk = ~clk;

  pause_resolver #(.WM_W(WM_W)) u0 (.*);

  task automatic chk(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int resolveExp(int req, bit lp, bit la, bit pp, bit pa, bit fd);
    int m;
    if (lp && pp) m = (req == 3 || req == 4) ? 3 : 1;
    else if (!lp && la && pp && pa) m = 2;
    else if (lp && la && !pp && pa) m = 1;
    else m = 0;
    if (!fd) m = 0;
    return m;
  endfunction

  task automatic checkAll(string tag);
    int tx = (expMode == 2 || expMode == 3) ? 1 : 0;
    int rx = (expMode == 1 || expMode == 3) ? 1 : 0;
    chk({tag, " R9 mode"}, int'(modeOut), expMode);
    chk({tag, " R9 tx"}, int'(txPauseEn), tx);
    chk({tag, " R9 rx"}, int'(rxPauseEn), rx);
    chk({tag, " R3 err"}, int'(cfgErr), expErr);
    chk({tag, " R10 high"}, int'(highWaterOut), tx ? int'(highWaterIn) : 0);
    chk({tag, " R10 low"}, int'(lowWaterOut[WM_W-1:0]), tx ? int'(lowWaterIn) : 0);
    chk({tag, " R11 xon"}, int'(lowWaterOut[WM_W]), tx ? int'(xonEnable) : 0);
  endtask

  task automatic strobe(int req, logic [3:0] adv, bit fd, bit en, bit done);
    @(negedge clk);
    reqMode = 3'(req);
    {localPause, localAsym, peerPause, peerAsym} = adv;
    fullDuplex = fd;
    anEnable = en;
    anDone = done;
    resolveStb = 1'b1;
    @(negedge clk);
    resolveStb = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkAll("R1 reset");

    // R4 R5 R6 R7 R8 R3: full sweep
    for (int req = 0; req < 8; req++) begin
      for (int adv = 0; adv < 16; adv++) begin
        for (int fd = 0; fd < 2; fd++) begin
          xonEnable = adv[0] ^ fd[0] ^ req[0];
          lowWaterIn = 16'(16'h1234 + adv * 16'h0111);
          highWaterIn = 16'(16'hABCD - req * 16'h0101);
          strobe(req, 4'(adv), fd[0], 1'b1, 1'b1);
          if (req <= 4) begin
            expMode = resolveExp(req, adv[3], adv[2], adv[1], adv[0], fd[0]);
            expErr = 0;
          end else begin
            expErr = 1;
          end
          checkAll("R4-R8 sweep");
        end
      end
    end

    // R2: AN gating with mode held at full
    strobe(3, 4'b1010, 1'b1, 1'b1, 1'b1);
    expMode = 3; expErr = 0;
    checkAll("R2 setup full");
    for (int c = 0; c < 3; c++) begin
      strobe(0, 4'b0000, 1'b0, c[0], c[1]);
      checkAll("R2 an not ready held");
    end

    // R3: illegal request while AN not ready sets error, mode held
    strobe(6, 4'b0000, 1'b0, 1'b0, 1'b0);
    expErr = 1;
    checkAll("R3 illegal an off");
    // R3: legal request with AN off clears error, mode still held (R2)
    strobe(1, 4'b0000, 1'b0, 1'b0, 1'b1);
    expErr = 0;
    checkAll("R3 clear an off");

    // R2: inputs change without strobe
    @(negedge clk);
    anEnable = 1'b1; anDone = 1'b1; reqMode = 3'd0;
    {localPause, localAsym, peerPause, peerAsym} = 4'b0000;
    repeat (3) @(negedge clk);
    checkAll("R2 no strobe held");

    // R11: XON toggled while transmit pause active
    strobe(2, 4'b0111, 1'b1, 1'b1, 1'b1);
    expMode = 2;
    xonEnable = 1'b1;
    #1 checkAll("R11 xon on");
    xonEnable = 1'b0;
    #1 checkAll("R11 xon off");

    // R4: default request with symmetric pause gives full
    strobe(4, 4'b1111, 1'b1, 1'b1, 1'b1);
    expMode = 3;
    checkAll("R4 default full");

    finishRun();
  end
endmodule